// File: doc/BRIEF.md
# Sector Erase Gather Window

This block collects sector-erase requests into a single sector mask so that several sectors can be erased together in one pass. The first sector-erase command received while the block is idle opens an acceptance window and marks its sector. Each further sector-erase command that arrives while the window is open adds its sector to the mask and restarts the window timer. A falling write strobe seen while the window is open also restarts the timer.

When the window runs out with no restart, the block issues a one-cycle start pulse and enters the erase phase. A status bit reads 1 from that point onwards, and later sector-erase commands are ignored. Sectors that are marked protected are removed from the mask handed to the erase engine. Any other command received during the window or the erase abandons the operation with an abort pulse. The sectors that were selected must then be treated as holding invalid data. The erase engine reports completion on a done input, and the block then returns to idle.

The window length is the parameter WINDOW_CYCLES, counted in clock cycles, so a simulation can use a short window in place of the nominal 80 microseconds.

Top module: `sector_erase_gather`

## Requirements
- R1: After reset, mask_o, erase_mask_o, erase_start_o, abort_o and window_closed_o are all 0.
- R2: A se_cmd_i in idle opens the window and sets mask_o to a one-hot value in which bit n corresponds to sector number n on se_sector_i. other_cmd_i has no effect in idle.
- R3: A se_cmd_i while the window is open ORs its sector bit into mask_o and restarts the timer. If the sector is already in the mask, the mask is unchanged but the timer still restarts. Sectors may be loaded in any order.
- R4: A wr_fall_i while the window is open restarts the timer and leaves mask_o unchanged.
- R5: If the last restart is sampled at clock edge k, erase_start_o is high for exactly one cycle, after edge k+WINDOW_CYCLES. It is not high earlier.
- R6: window_closed_o is 1 from the start pulse until erase_done_i or an abort. While it is 1, se_cmd_i leaves mask_o unchanged.
- R7: erase_mask_o always equals mask_o with every sector removed whose bit is set in protect_i.
- R8: other_cmd_i during the window or the erase gives a one-cycle abort_o on the next cycle, clears mask_o and returns to idle.
- R9: erase_done_i during the erase clears mask_o and window_closed_o.
- R10: If other_cmd_i and se_cmd_i arrive in the same cycle while the window is open, the abort wins and the sector is not added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| se_cmd_i | input | 1 | Sector-erase command strobe |
| se_sector_i | input | SECT_W | Sector number carried by se_cmd_i |
| other_cmd_i | input | 1 | Strobe for any command other than sector erase |
| wr_fall_i | input | 1 | Falling edge of the write strobe |
| erase_done_i | input | 1 | Erase engine has finished |
| protect_i | input | NUM_SECTORS | Per-sector protection flags |
| mask_o | output | NUM_SECTORS | Accumulated selected sectors |
| erase_mask_o | output | NUM_SECTORS | Selected sectors minus protected ones |
| erase_start_o | output | 1 | One-cycle erase start pulse |
| abort_o | output | 1 | One-cycle abort pulse |
| window_closed_o | output | 1 | 1 once the window has expired and the erase runs |

## Verification
The assertions check on every cycle that the mask only grows while the window is open, and that a command in the closed state leaves the mask untouched. They also check that an abort clears the mask, that start and abort pulses last a single cycle and never coincide, and that the timer stays within its range. Only the bench scenarios can show the exact expiry cycle after a chain of restarts, duplicate loads, and the priority of an abort over a simultaneous load. The same holds for the interplay of protection with the final mask. A cycle model in the bench checks all of these against random command mixes.

// File: rtl/sge_pkg.sv
package sge_pkg;
  typedef enum logic [1:0] {
    SG_IDLE   = 2'd0,
    SG_WINDOW = 2'd1,
    SG_ERASE  = 2'd2
  } sg_state_e;
endpackage

// File: rtl/sge_sector_decode.sv
module sge_sector_decode #(
  parameter int NUM_SECTORS = 8,
  localparam int SECT_W = $clog2(NUM_SECTORS)
) (
  input  logic [SECT_W-1:0]      sector_i,
  output logic [NUM_SECTORS-1:0] onehot_o
);
  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_dec
    assign onehot_o[i] = (sector_i == SECT_W'(i));
  end
endmodule

// File: rtl/sge_window_timer.sv
module sge_window_timer #(
  parameter int WINDOW_CYCLES = 16,
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= CNT_W'(WINDOW_CYCLES);
    else if (load_i)                      cnt_q <= CNT_W'(WINDOW_CYCLES);
    else if (run_i && cnt_q > CNT_W'(1))  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expire_o = run_i && !load_i && (cnt_q == CNT_W'(1));

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= CNT_W'(1)) && (cnt_q <= CNT_W'(WINDOW_CYCLES))); // R5
  AST_LOAD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !expire_o || (WINDOW_CYCLES == 1)); // R5
endmodule

// File: rtl/sector_erase_gather.sv
module sector_erase_gather
  import sge_pkg::*;
#(
  parameter int NUM_SECTORS   = 8,
  parameter int WINDOW_CYCLES = 16,
  localparam int SECT_W = $clog2(NUM_SECTORS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   se_cmd_i,
  input  logic [SECT_W-1:0]      se_sector_i,
  input  logic                   other_cmd_i,
  input  logic                   wr_fall_i,
  input  logic                   erase_done_i,
  input  logic [NUM_SECTORS-1:0] protect_i,
  output logic [NUM_SECTORS-1:0] mask_o,
  output logic [NUM_SECTORS-1:0] erase_mask_o,
  output logic                   erase_start_o,
  output logic                   abort_o,
  output logic                   window_closed_o
);
  sg_state_e              state_q, state_d;
  logic [NUM_SECTORS-1:0] mask_q, mask_d, sect_oh;
  logic                   start_q, start_d, abort_q, abort_d;
  logic                   tmr_load, tmr_run, tmr_expire;

  sge_sector_decode #(.NUM_SECTORS(NUM_SECTORS)) u_dec (
    .sector_i (se_sector_i),
    .onehot_o (sect_oh)
  );

  assign tmr_load = ((state_q == SG_IDLE) && se_cmd_i) ||
                    ((state_q == SG_WINDOW) && !other_cmd_i && (se_cmd_i || wr_fall_i));
  assign tmr_run  = (state_q == SG_WINDOW) && !other_cmd_i;

  sge_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .run_i    (tmr_run),
    .expire_o (tmr_expire)
  );

  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    start_d = 1'b0;
    abort_d = 1'b0;
    unique case (state_q)
      SG_IDLE: if (se_cmd_i) begin
        state_d = SG_WINDOW;
        mask_d  = sect_oh;
      end
      SG_WINDOW: begin
        if (other_cmd_i) begin
          state_d = SG_IDLE;
          mask_d  = '0;
          abort_d = 1'b1;
        end else if (se_cmd_i) begin
          mask_d = mask_q | sect_oh;
        end else if (tmr_expire) begin
          state_d = SG_ERASE;
          start_d = 1'b1;
        end
      end
      SG_ERASE: begin
        if (other_cmd_i) begin
          state_d = SG_IDLE;
          mask_d  = '0;
          abort_d = 1'b1;
        end else if (erase_done_i) begin
          state_d = SG_IDLE;
          mask_d  = '0;
        end
      end
      default: begin
        state_d = SG_IDLE;
        mask_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SG_IDLE;
      mask_q  <= '0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
      start_q <= start_d;
      abort_q <= abort_d;
    end
  end

  assign mask_o          = mask_q;
  assign erase_mask_o    = mask_q & ~protect_i;
  assign erase_start_o   = start_q;
  assign abort_o         = abort_q;
  assign window_closed_o = (state_q == SG_ERASE);

  AST_OPEN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SG_IDLE && se_cmd_i) |=> $onehot0(mask_o) && mask_o != '0); // R2
  AST_MASK_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SG_WINDOW && !other_cmd_i) |=> ((mask_o & $past(mask_o)) == $past(mask_o))); // R3
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |=> !erase_start_o); // R5
  AST_START_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |-> (mask_o != '0) && window_closed_o && !abort_o); // R5
  AST_CLOSED_IGNORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (window_closed_o && se_cmd_i && !other_cmd_i && !erase_done_i) |=> $stable(mask_o)); // R6
  AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != SG_IDLE && other_cmd_i) |=> abort_o && mask_o == '0 && !window_closed_o); // R8
  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o); // R8
endmodule

// File: tb/sector_erase_gather_bench.sv
module sector_erase_gather_bench;
  localparam int NS  = 8;
  localparam int SW  = 3;
  localparam int WIN = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic se = 1'b0, oth = 1'b0, wf = 1'b0, done = 1'b0;
  logic [SW-1:0] sec = '0;
  logic [NS-1:0] prot = '0;
  logic [NS-1:0] mask, emask;
  logic start, abrt, closed;

  int checks = 0;
  int errors = 0;

  // bench cycle model: 0 idle, 1 window, 2 erase
  int m_state = 0;
  int m_cnt = WIN;
  logic [NS-1:0] m_mask = '0;
  logic m_start = 1'b0, m_abort = 1'b0;

  always #5 clk = ~clk;

  sector_erase_gather #(.NUM_SECTORS(NS), .WINDOW_CYCLES(WIN)) u_sector_erase_gather (
    .clk_i(clk), .rst_ni(rst_n), .se_cmd_i(se), .se_sector_i(sec),
    .other_cmd_i(oth), .wr_fall_i(wf), .erase_done_i(done), .protect_i(prot),
    .mask_o(mask), .erase_mask_o(emask), .erase_start_o(start),
    .abort_o(abrt), .window_closed_o(closed)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    m_start = 1'b0;
    m_abort = 1'b0;
    case (m_state)
      0: if (se) begin m_state = 1; m_mask = NS'(1) << sec; m_cnt = WIN; end
      1: begin
        if (oth) begin m_state = 0; m_mask = '0; m_abort = 1'b1; end
        else if (se) begin m_mask = m_mask | (NS'(1) << sec); m_cnt = WIN; end
        else if (wf) m_cnt = WIN;
        else if (m_cnt == 1) begin m_state = 2; m_start = 1'b1; end
        else m_cnt--;
      end
      default: begin
        if (oth) begin m_state = 0; m_mask = '0; m_abort = 1'b1; end
        else if (done) begin m_state = 0; m_mask = '0; end
      end
    endcase
  endtask

  task automatic compare_model();
    check("R3 mask vs model", 32'(mask), 32'(m_mask));
    check("R7 erase mask vs model", 32'(emask), 32'(m_mask & ~prot));
    check("R5 start vs model", 32'(start), 32'(m_start));
    check("R8 abort vs model", 32'(abrt), 32'(m_abort));
    check("R6 status vs model", 32'(closed), 32'(m_state == 2));
  endtask

  // apply inputs for one edge, then sample 1 ns after it
  task automatic step(input logic s, input int n, input logic o, input logic w, input logic d);
    se = s; sec = SW'(n); oth = o; wf = w; done = d;
    model_step();
    @(posedge clk); #1;
    se = 0; oth = 0; wf = 0; done = 0;
    compare_model();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #22 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    check("R1 mask", 32'(mask), 0);
    check("R1 start", 32'(start), 0);
    check("R1 abort", 32'(abrt), 0);
    check("R1 status", 32'(closed), 0);
    check("R1 erase mask", 32'(emask), 0);

    // R2 open with sector 5; other_cmd in idle has no effect
    step(0, 0, 1, 0, 0);
    check("R2 idle other no abort", 32'(abrt), 0);
    step(1, 5, 0, 0, 0);
    check("R2 open mask", 32'(mask), 32'h20);
    idle(3);
    step(1, 2, 0, 0, 0);
    check("R3 add sector", 32'(mask), 32'h24);
    idle(4);
    step(1, 5, 0, 0, 0);
    check("R3 duplicate unchanged", 32'(mask), 32'h24);
    idle(WIN - 2);
    step(0, 0, 0, 1, 0);
    check("R4 wr_fall mask unchanged", 32'(mask), 32'h24);
    idle(WIN - 1);
    check("R5 not yet started", 32'(start), 0);
    prot = 8'h04;
    step(0, 0, 0, 0, 0);
    check("R5 start pulse", 32'(start), 1);
    check("R6 status closed", 32'(closed), 1);
    check("R7 protected removed", 32'(emask), 32'h20);
    step(1, 7, 0, 0, 0);
    check("R5 pulse one cycle", 32'(start), 0);
    check("R6 se ignored", 32'(mask), 32'h24);
    step(0, 0, 0, 0, 1);
    check("R9 done clears mask", 32'(mask), 0);
    check("R9 done clears status", 32'(closed), 0);
    prot = '0;

    // R8 abort during window, R10 priority
    step(1, 0, 0, 0, 0);
    step(1, 3, 1, 0, 0);
    check("R10 abort wins", 32'(abrt), 1);
    check("R10 sector not added", 32'(mask), 0);
    step(0, 0, 0, 0, 0);
    check("R8 abort one cycle", 32'(abrt), 0);

    // R8 abort during erase; R3 all eight sectors any order
    for (int i = 0; i < NS; i++) step(1, (i * 5) % NS, 0, 0, 0);
    check("R3 all sectors", 32'(mask), 32'hFF);
    idle(WIN);
    check("R6 closed after full", 32'(closed), 1);
    step(0, 0, 1, 0, 0);
    check("R8 abort in erase", 32'(abrt), 1);
    check("R8 mask cleared", 32'(mask), 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (($urandom_range(0, 49)) == 0) prot = NS'($urandom());
      step(r < 15, int'($urandom_range(0, NS - 1)), r >= 96,
           (r >= 15 && r < 25), (r >= 25 && r < 30));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule